// File: doc/BRIEF.md
# Wiper Register I2C Target

This block is a serial-bus target that owns the wiper-position registers of a dual-channel digital potentiometer. A fast system clock oversamples the SCL and SDA lines, finds their edges and the START and STOP conditions, and runs the byte protocol. The target drives SDA only through an open-drain enable. Each channel's tap value appears on a parallel output for the analog section that follows.

A controller sets one wiper by sending START, an identification byte, a register address byte, one data byte and STOP. It can set every channel in one transaction by sending more data bytes before STOP. A data byte reaches its register on the ninth SCL clock of that byte. To read, the controller sends the identification byte with R/W low, then an address byte, then a repeated START, then the identification byte with R/W high. The target then sends register contents until the controller answers with NACK.

Top module: `wiper_i2c_target`

## Requirements
- R1: An identification byte whose upper nibble is 4'b0101 and whose bits [3:1] equal addr_pins is acknowledged: sda_oe is high while SCL is high in the ninth clock. Bit 0 of that byte is R/W, where 1 means read.
- R2: An identification byte with a wrong nibble or wrong pin bits gets no acknowledge. The target then acknowledges no byte and changes no register until the next START.
- R3: After a matching write identification, the next byte is always acknowledged and becomes the register pointer.
- R4: A write data byte whose pointer is below NUM_CH is acknowledged. Its low WIPER_W bits (bits [6:0] by default, bit 7 dropped) appear on that channel's slice of wiper_o only after the ninth SCL rising edge of the byte. Channel c occupies wiper_o[c*WIPER_W +: WIPER_W].
- R5: Each further data byte before STOP goes to the register after the previous one, because the pointer advances by one after every data byte.
- R6: A data byte whose pointer is NUM_CH or above is not acknowledged and changes no register.
- R7: After the repeated START and a matching identification with R/W=1, the target acknowledges, then sends the register at the pointer MSB first, with the unused upper bits as 0. Each controller ACK makes it send the next register.
- R8: A read at a pointer of NUM_CH or above returns 8'h00.
- R9: The target releases SDA (sda_oe low) during the controller's ACK/NACK bit. After a NACK it keeps SDA released until the next START or STOP.
- R10: sda_oe changes only while the sampled SCL is low, except for the release caused by a START or STOP.
- R11: A STOP or a reset returns the protocol to idle with sda_oe low, and the wiper registers keep their values through both.
- R12: From power-up, every wiper register holds INIT_TAP (7'h40 by default).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset of the protocol logic |
| scl_i | input | 1 | Serial clock line as seen on the pad |
| sda_i | input | 1 | Serial data line as seen on the pad |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| addr_pins | input | 3 | Hardware address straps compared with identification bits [3:1] |
| wiper_o | output | NUM_CH*WIPER_W | Concatenated wiper tap values, channel 0 in the low bits |

## Verification
The bench builds the block with its default parameters: two channels, 7-bit wipers, a two-stage synchronizer and 4'b0101 as the fixed nibble. It drives addr_pins to 3'b101, so a pin mismatch is distinct from the all-zero case. Two channels make the pointer reach the first out-of-range address after only one sequential step. This exposes the NACK on a third data byte and the 8'h00 read at address 2. The 7-bit width leaves bit 7 of each data byte to be dropped, and the bench writes a byte with that bit set to show it.

// File: rtl/wiper_i2c_pkg.sv
`timescale 1ns/1ps
package wiper_i2c_pkg;
   localparam int BYTE_W = 8;
   localparam int PTR_W  = 8;
   localparam int CNT_W  = 4;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_ID     = 3'd1,
      ST_ADDR   = 3'd2,
      ST_WDATA  = 3'd3,
      ST_READ   = 3'd4,
      ST_IGNORE = 3'd5
   } tgt_state_e;
endpackage

// File: rtl/i2c_line_sampler.sv
`timescale 1ns/1ps
module i2c_line_sampler #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_evt,
   output logic stop_evt
);
   logic [SYNC_STAGES-1:0] scl_ff;
   logic [SYNC_STAGES-1:0] sda_ff;
   logic                   scl_q;
   logic                   sda_q;

   generate
      if (SYNC_STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_ff <= '1;
               sda_ff <= '1;
            end else begin
               scl_ff <= scl_i;
               sda_ff <= sda_i;
            end
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_ff <= '1;
               sda_ff <= '1;
            end else begin
               scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
               sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
            end
         end
      end
   endgenerate

   assign scl_s = scl_ff[SYNC_STAGES-1];
   assign sda_s = sda_ff[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/wiper_reg_bank.sv
`timescale 1ns/1ps
module wiper_reg_bank
   import wiper_i2c_pkg::*;
#(
   parameter int NUM_CH   = 2,
   parameter int WIPER_W  = 7,
   parameter int INIT_TAP = 64
) (
   input  logic                        clk,
   input  logic                        wr_en,
   input  logic [PTR_W-1:0]            wr_idx,
   input  logic [WIPER_W-1:0]          wr_val,
   input  logic [PTR_W-1:0]            rd_idx,
   output logic [BYTE_W-1:0]           rd_byte,
   output logic [NUM_CH*WIPER_W-1:0]   wiper_flat
);
   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic [WIPER_W-1:0] tap_q = WIPER_W'(INIT_TAP);
         always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == PTR_W'(c)))
               tap_q <= wr_val;
         end
         assign wiper_flat[c*WIPER_W +: WIPER_W] = tap_q;
      end
   endgenerate

   always_comb begin
      rd_byte = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (rd_idx == PTR_W'(c))
            rd_byte = BYTE_W'(wiper_flat[c*WIPER_W +: WIPER_W]);
      end
   end
endmodule

// File: rtl/i2c_target_fsm.sv
`timescale 1ns/1ps
module i2c_target_fsm
   import wiper_i2c_pkg::*;
#(
   parameter int         NUM_CH     = 2,
   parameter int         WIPER_W    = 7,
   parameter logic [3:0] ID_NIBBLE  = 4'b0101
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sda_s,
   input  logic               scl_rise,
   input  logic               scl_fall,
   input  logic               start_evt,
   input  logic               stop_evt,
   input  logic [2:0]         addr_pins,
   input  logic [BYTE_W-1:0]  rd_byte,
   output logic [PTR_W-1:0]   rd_ptr,
   output logic               wr_en,
   output logic [PTR_W-1:0]   wr_idx,
   output logic [WIPER_W-1:0] wr_val,
   output logic               sda_oe,
   output tgt_state_e         state
);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(8);
   localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(9);

   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] shreg;
   logic [BYTE_W-1:0] tx_q;
   logic [PTR_W-1:0]  ptr;
   logic              ack_q;
   logic              byte_ok;
   logic              ptr_ok;

   assign ptr_ok = int'(ptr) < NUM_CH;

   always_comb begin
      case (state)
         ST_ID:    byte_ok = (shreg[7:4] == ID_NIBBLE) && (shreg[3:1] == addr_pins);
         ST_ADDR:  byte_ok = 1'b1;
         ST_WDATA: byte_ok = ptr_ok;
         default:  byte_ok = 1'b0;
      endcase
   end

   assign rd_ptr = (state == ST_READ) ? ptr + PTR_W'(1) : ptr;
   assign wr_en  = (state == ST_WDATA) && scl_rise && (bit_cnt == ACK_BIT) && ack_q;
   assign wr_idx = ptr;
   assign wr_val = shreg[WIPER_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         bit_cnt <= '0;
         shreg   <= '0;
         tx_q    <= '0;
         ptr     <= '0;
         ack_q   <= 1'b0;
         sda_oe  <= 1'b0;
      end else if (start_evt) begin
         state   <= ST_ID;
         bit_cnt <= '0;
         ack_q   <= 1'b0;
         sda_oe  <= 1'b0;
      end else if (stop_evt) begin
         state   <= ST_IDLE;
         bit_cnt <= '0;
         ack_q   <= 1'b0;
         sda_oe  <= 1'b0;
      end else begin
         case (state)
            ST_ID, ST_ADDR, ST_WDATA: begin
               if (scl_rise && (bit_cnt < LAST_BIT)) begin
                  shreg   <= {shreg[BYTE_W-2:0], sda_s};
                  bit_cnt <= bit_cnt + CNT_W'(1);
               end else if (scl_fall && (bit_cnt == LAST_BIT)) begin
                  bit_cnt <= ACK_BIT;
                  ack_q   <= byte_ok;
                  sda_oe  <= byte_ok;
                  if (state == ST_ADDR)
                     ptr <= shreg;
               end else if (scl_fall && (bit_cnt == ACK_BIT)) begin
                  bit_cnt <= '0;
                  sda_oe  <= 1'b0;
                  case (state)
                     ST_ID: begin
                        if (!ack_q) begin
                           state <= ST_IGNORE;
                        end else if (shreg[0]) begin
                           state  <= ST_READ;
                           tx_q   <= rd_byte;
                           sda_oe <= ~rd_byte[BYTE_W-1];
                        end else begin
                           state <= ST_ADDR;
                        end
                     end
                     ST_ADDR:  state <= ST_WDATA;
                     default:  ptr   <= ptr + PTR_W'(1);
                  endcase
               end
            end
            ST_READ: begin
               if (scl_rise && (bit_cnt < LAST_BIT)) begin
                  bit_cnt <= bit_cnt + CNT_W'(1);
               end else if (scl_fall && (bit_cnt != '0) && (bit_cnt < LAST_BIT)) begin
                  sda_oe <= ~tx_q[3'd7 - bit_cnt[2:0]];
               end else if (scl_fall && (bit_cnt == LAST_BIT)) begin
                  sda_oe  <= 1'b0;
                  bit_cnt <= ACK_BIT;
               end else if (scl_rise && (bit_cnt == ACK_BIT)) begin
                  ack_q <= ~sda_s;
               end else if (scl_fall && (bit_cnt == ACK_BIT)) begin
                  bit_cnt <= '0;
                  ptr     <= ptr + PTR_W'(1);
                  if (ack_q) begin
                     tx_q   <= rd_byte;
                     sda_oe <= ~rd_byte[BYTE_W-1];
                  end else begin
                     state  <= ST_IGNORE;
                     sda_oe <= 1'b0;
                  end
               end
            end
            default: begin
               sda_oe <= 1'b0;
            end
         endcase
      end
   end
endmodule

// File: rtl/wiper_i2c_target.sv
`timescale 1ns/1ps
module wiper_i2c_target
   import wiper_i2c_pkg::*;
#(
   parameter int         NUM_CH      = 2,
   parameter int         WIPER_W     = 7,
   parameter int         INIT_TAP    = 64,
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] ID_NIBBLE   = 4'b0101
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      scl_i,
   input  logic                      sda_i,
   output logic                      sda_oe,
   input  logic [2:0]                addr_pins,
   output logic [NUM_CH*WIPER_W-1:0] wiper_o
);
   initial begin : g_param_chk
      if (NUM_CH < 1 || NUM_CH > 255)
         $error("wiper_i2c_target: NUM_CH out of range");
      if (WIPER_W < 1 || WIPER_W > BYTE_W)
         $error("wiper_i2c_target: WIPER_W must fit in one byte");
      if (SYNC_STAGES < 1)
         $error("wiper_i2c_target: SYNC_STAGES must be at least 1");
      if (INIT_TAP < 0 || INIT_TAP >= (1 << WIPER_W))
         $error("wiper_i2c_target: INIT_TAP exceeds wiper width");
   end

   logic              scl_s;
   logic              sda_s;
   logic              scl_rise;
   logic              scl_fall;
   logic              start_evt;
   logic              stop_evt;
   logic [PTR_W-1:0]  rd_ptr;
   logic [BYTE_W-1:0] rd_byte;
   logic              wr_en;
   logic [PTR_W-1:0]  wr_idx;
   logic [WIPER_W-1:0] wr_val;
   tgt_state_e        state;

   i2c_line_sampler #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_sampler (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_evt (start_evt),
      .stop_evt  (stop_evt)
   );

   i2c_target_fsm #(
      .NUM_CH    (NUM_CH),
      .WIPER_W   (WIPER_W),
      .ID_NIBBLE (ID_NIBBLE)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_evt (start_evt),
      .stop_evt  (stop_evt),
      .addr_pins (addr_pins),
      .rd_byte   (rd_byte),
      .rd_ptr    (rd_ptr),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_val    (wr_val),
      .sda_oe    (sda_oe),
      .state     (state)
   );

   wiper_reg_bank #(
      .NUM_CH   (NUM_CH),
      .WIPER_W  (WIPER_W),
      .INIT_TAP (INIT_TAP)
   ) u_bank (
      .clk        (clk),
      .wr_en      (wr_en),
      .wr_idx     (wr_idx),
      .wr_val     (wr_val),
      .rd_idx     (rd_ptr),
      .rd_byte    (rd_byte),
      .wiper_flat (wiper_o)
   );
endmodule

// File: rtl/wiper_i2c_target_chk.sv
`timescale 1ns/1ps
module wiper_i2c_target_chk
   import wiper_i2c_pkg::*;
#(
   parameter int NUM_CH  = 2,
   parameter int WIPER_W = 7
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      scl_s,
   input logic                      scl_rise,
   input logic                      start_evt,
   input logic                      stop_evt,
   input logic                      sda_oe,
   input tgt_state_e                state,
   input logic [NUM_CH*WIPER_W-1:0] wiper_o
);
   AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sda_oe) && !$past(start_evt || stop_evt)) |-> !scl_s); // R10

   AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> (state == ST_IDLE && !sda_oe)); // R11

   AST_START_ID: assert property (@(posedge clk) disable iff (!rst_n)
      start_evt |=> (state == ST_ID)); // R2

   AST_QUIET_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IGNORE || state == ST_IDLE) |-> !sda_oe); // R9

   AST_COMMIT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wiper_o) |-> ($past(scl_rise) && $past(state) == ST_WDATA)); // R4
endmodule

bind wiper_i2c_target wiper_i2c_target_chk #(
   .NUM_CH  (NUM_CH),
   .WIPER_W (WIPER_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_s     (scl_s),
   .scl_rise  (scl_rise),
   .start_evt (start_evt),
   .stop_evt  (stop_evt),
   .sda_oe    (sda_oe),
   .state     (state),
   .wiper_o   (wiper_o)
);

// File: tb/wiper_i2c_target_test.sv
`timescale 1ns/1ps
module wiper_i2c_target_test;
   localparam int Q = 100;

   typedef struct packed {
      logic [7:0] reg_addr;
      logic [7:0] val;
      logic       ack;
      logic [6:0] e0;
      logic [6:0] e1;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{8'h00, 8'h15, 1'b1, 7'h15, 7'h40},
      '{8'h01, 8'h7F, 1'b1, 7'h15, 7'h7F},
      '{8'h00, 8'hA3, 1'b1, 7'h23, 7'h7F},
      '{8'h02, 8'h11, 1'b0, 7'h23, 7'h7F},
      '{8'hFF, 8'h00, 1'b0, 7'h23, 7'h7F},
      '{8'h01, 8'h80, 1'b1, 7'h23, 7'h00}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1;
   logic        sda_m = 1'b1;
   logic [2:0]  pins = 3'b101;
   logic        sda_oe;
   logic [13:0] wiper_o;
   wire         sda_line = sda_m & ~sda_oe;
   logic [13:0] pre9;
   int          checks = 0;
   int          errors = 0;
   bit          done = 0;

   wiper_i2c_target uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_m),
      .sda_i     (sda_line),
      .sda_oe    (sda_oe),
      .addr_pins (pins),
      .wiper_o   (wiper_o)
   );

   always #10 clk = ~clk;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic bus_start();
      sda_m = 1; scl_m = 1; #Q;
      sda_m = 0; #Q;
      scl_m = 0; #Q;
   endtask

   task automatic bus_rstart();
      sda_m = 1; #Q;
      scl_m = 1; #Q;
      sda_m = 0; #Q;
      scl_m = 0; #Q;
   endtask

   task automatic bus_stop();
      sda_m = 0; #Q;
      scl_m = 1; #Q;
      sda_m = 1; #(2*Q);
   endtask

   task automatic wr_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; #Q;
         scl_m = 1; #(2*Q);
         scl_m = 0; #Q;
      end
      sda_m = 1; #Q;
      pre9 = wiper_o;
      scl_m = 1; #Q;
      ack = (sda_line == 1'b0);
      #Q;
      scl_m = 0; #Q;
   endtask

   task automatic rd_byte(input bit mack, output logic [7:0] b, output logic oe_ack);
      sda_m = 1;
      for (int i = 7; i >= 0; i--) begin
         scl_m = 1; #Q;
         b[i] = sda_line; #Q;
         scl_m = 0; #(2*Q);
      end
      sda_m = ~mack;
      scl_m = 1; #Q;
      oe_ack = sda_oe; #Q;
      scl_m = 0; #Q;
      sda_m = 1; #Q;
   endtask

   initial begin : watchdog
      #4_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R1 watchdog: actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      bit         a;
      logic [7:0] rb;
      logic       oea;

      repeat (10) @(posedge clk);
      #5;
      chk("R12", "power-up wiper0", int'(wiper_o[6:0]), 'h40);
      chk("R12", "power-up wiper1", int'(wiper_o[13:7]), 'h40);
      chk("R11", "sda_oe in reset", int'(sda_oe), 0);
      rst_n = 1;
      #(4*Q);

      // table walk: R1, R3, R4, R6
      foreach (VECS[k]) begin
         bus_start();
         wr_byte({4'b0101, pins, 1'b0}, a);
         chk("R1", $sformatf("vec%0d id ack", k), int'(a), 1);
         wr_byte(VECS[k].reg_addr, a);
         chk("R3", $sformatf("vec%0d addr ack", k), int'(a), 1);
         wr_byte(VECS[k].val, a);
         chk("R6", $sformatf("vec%0d data ack", k), int'(a), int'(VECS[k].ack));
         bus_stop();
         chk("R4", $sformatf("vec%0d wiper0", k), int'(wiper_o[6:0]), int'(VECS[k].e0));
         chk("R4", $sformatf("vec%0d wiper1", k), int'(wiper_o[13:7]), int'(VECS[k].e1));
      end

      // R2: wrong nibble, then later bytes ignored
      bus_start();
      wr_byte({4'b0110, pins, 1'b0}, a);
      chk("R2", "bad nibble ack", int'(a), 0);
      wr_byte(8'h00, a);
      chk("R2", "ignored addr ack", int'(a), 0);
      wr_byte(8'h55, a);
      chk("R2", "ignored data ack", int'(a), 0);
      bus_stop();
      chk("R2", "wiper0 untouched", int'(wiper_o[6:0]), 'h23);

      // R2: wrong pins
      bus_start();
      wr_byte({4'b0101, 3'b001, 1'b0}, a);
      chk("R2", "bad pins ack", int'(a), 0);
      bus_stop();

      // R4/R5/R6: sequential write, ninth-clock commit
      bus_start();
      wr_byte({4'b0101, pins, 1'b0}, a);
      wr_byte(8'h00, a);
      wr_byte(8'h0A, a);
      chk("R4", "seq byte0 ack", int'(a), 1);
      chk("R4", "wiper0 before ninth clock", int'(pre9[6:0]), 'h23);
      chk("R4", "wiper0 after ninth clock", int'(wiper_o[6:0]), 'h0A);
      wr_byte(8'h0B, a);
      chk("R5", "seq byte1 ack", int'(a), 1);
      chk("R5", "wiper1 from sequence", int'(wiper_o[13:7]), 'h0B);
      wr_byte(8'h0C, a);
      chk("R6", "seq byte2 past bank ack", int'(a), 0);
      bus_stop();
      chk("R6", "wiper0 after overrun", int'(wiper_o[6:0]), 'h0A);
      chk("R6", "wiper1 after overrun", int'(wiper_o[13:7]), 'h0B);
      chk("R11", "sda_oe after stop", int'(sda_oe), 0);

      // R7/R9: random read of both channels
      bus_start();
      wr_byte({4'b0101, pins, 1'b0}, a);
      wr_byte(8'h00, a);
      bus_rstart();
      wr_byte({4'b0101, pins, 1'b1}, a);
      chk("R7", "read id ack", int'(a), 1);
      rd_byte(1'b1, rb, oea);
      chk("R7", "read ch0", int'(rb), 'h0A);
      chk("R9", "oe during controller ack", int'(oea), 0);
      rd_byte(1'b0, rb, oea);
      chk("R7", "read ch1 after ack", int'(rb), 'h0B);
      chk("R9", "oe during controller nack", int'(oea), 0);
      sda_m = 1; scl_m = 1; #Q;
      chk("R9", "released after nack", int'(sda_oe), 0);
      #Q; scl_m = 0; #(2*Q);
      chk("R9", "still released", int'(sda_oe), 0);
      bus_stop();

      // R8: out-of-range read
      bus_start();
      wr_byte({4'b0101, pins, 1'b0}, a);
      wr_byte(8'h02, a);
      bus_rstart();
      wr_byte({4'b0101, pins, 1'b1}, a);
      rd_byte(1'b0, rb, oea);
      chk("R8", "read past bank", int'(rb), 0);
      bus_stop();

      // R11: reset keeps wiper values
      rst_n = 0;
      repeat (5) @(posedge clk);
      #5;
      chk("R11", "wiper0 through reset", int'(wiper_o[6:0]), 'h0A);
      chk("R11", "wiper1 through reset", int'(wiper_o[13:7]), 'h0B);
      chk("R11", "sda_oe in reset", int'(sda_oe), 0);
      rst_n = 1;
      #(4*Q);

      // R4: writes still work after reset
      bus_start();
      wr_byte({4'b0101, pins, 1'b0}, a);
      wr_byte(8'h01, a);
      wr_byte(8'h33, a);
      bus_stop();
      chk("R4", "wiper1 write after reset", int'(wiper_o[13:7]), 'h33);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule